// File: doc/BRIEF.md
# Reservation Station Wakeup and Select Pool

This block is a small pool of reservation stations that sits in front of a single functional unit. Renamed instructions arrive on an issue port carrying an operation code and, for each of two sources, either a value (tag zero) or the tag of the station that will produce it. The pool places each instruction in a free entry and returns that entry's tag so the renamer can record it as the pending producer of the destination register.

Waiting operands are filled from a broadcast bus that carries a valid bit, a 4-bit producer tag and 64 data bits. An operand counts as ready exactly when its stored tag is zero; no separate ready flag exists. Among entries whose two operands are ready and which have not yet been handed to the unit, the one issued earliest is offered on a valid/ready dispatch port. Once the unit's result has been broadcast, the surrounding logic releases the entry by naming its tag on the free port.

Top module: `rs_pool`

## Requirements
- R1: After rst_ni is asserted, every entry is empty: iss_ready_o is 1, iss_slot_o is 1 and disp_valid_o is 0.
- R2: When iss_valid_i and iss_ready_o are both high, the lowest-numbered empty entry is taken and iss_slot_o shows its tag (entry k has tag k+1, so tags are 1 to 3). With every entry busy, iss_ready_o is 0 and an issue request changes no entry.
- R3: An issued operand whose tag is 0 is ready and holds the supplied value; an operand with a nonzero tag waits.
- R4: A broadcast with bc_valid_i high and a nonzero tag fills every waiting operand of a busy entry whose tag matches, both operands of one entry included, and clears that tag; the woken entry can be offered for dispatch in the cycle after the broadcast and not in the broadcast cycle.
- R5: An operand issued in the same cycle as a broadcast carrying its tag takes the broadcast data and is ready from the next cycle.
- R6: disp_valid_o is high only while some entry is busy, not yet dispatched and has both operand tags zero.
- R7: Among dispatchable entries the one issued earliest is offered, whatever its entry number.
- R8: An entry accepted on the dispatch port (disp_valid_o and disp_ready_i both high) is never offered again; while disp_ready_i is low the offered entry stays offered unless an older one becomes ready.
- R9: free_valid_i with the tag of a busy entry empties it, so it can be issued into from the next cycle; a free tag that is outside 1 to 3 or names an empty entry has no effect.
- R10: The dispatch port carries the entry's operation code, both operand values (first source on disp_a_o, second on disp_b_o) and the entry's tag.
- R11: A broadcast with tag 0, or with a tag no waiting operand holds, changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | Issue request |
| iss_op_i | input | 4 | Operation code of the issued instruction |
| iss_a_tag_i | input | 4 | First source producer tag, 0 when the value is present |
| iss_a_val_i | input | 64 | First source value |
| iss_b_tag_i | input | 4 | Second source producer tag, 0 when the value is present |
| iss_b_val_i | input | 64 | Second source value |
| iss_ready_o | output | 1 | An empty entry exists |
| iss_slot_o | output | 4 | Tag of the entry the next issue will take |
| bc_valid_i | input | 1 | Broadcast bus valid |
| bc_tag_i | input | 4 | Tag of the producing station |
| bc_data_i | input | 64 | Broadcast result |
| disp_valid_o | output | 1 | An entry is offered to the functional unit |
| disp_ready_i | input | 1 | Functional unit accepts the offered entry |
| disp_op_o | output | 4 | Operation code of the offered entry |
| disp_a_o | output | 64 | First operand value |
| disp_b_o | output | 64 | Second operand value |
| disp_tag_o | output | 4 | Tag of the offered entry |
| free_valid_i | input | 1 | Release request |
| free_tag_i | input | 4 | Tag of the entry to release |

## Verification
The cycle where an issue meets a broadcast carrying the incoming operand's tag is the critical overlap: the bench issues a waiting operand while the bus carries the matching tag and judges it by the entry appearing on dispatch one cycle later with the broadcast value. A second overlap is a dispatch acceptance in the same cycle as the release of another entry and a new issue, which the bench provokes in one step and judges by the age order of the entries offered afterwards, including an older entry in a higher slot winning over a younger one in slot 1.

// File: rtl/rs_pool_pkg.sv
`timescale 1ns/1ps
package rs_pool_pkg;
  localparam int DATA_W = 64;
  localparam int TAG_W  = 4;
  localparam int OP_W   = 4;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] val;
  } opnd_t;

  // take bus data when the operand waits on the broadcast tag
  function automatic opnd_t snoop(opnd_t o, logic bv, logic [TAG_W-1:0] bt,
                                  logic [DATA_W-1:0] bd);
    opnd_t r;
    r = o;
    if (bv && o.tag != '0 && o.tag == bt) begin
      r.tag = '0;
      r.val = bd;
    end
    return r;
  endfunction
endpackage

// File: rtl/rs_alloc.sv
`timescale 1ns/1ps
module rs_alloc #(
  parameter int N_ENT = 3,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic [N_ENT-1:0] busy_i,
  output logic             free_any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N_ENT-1:0] oh_o
);
  always_comb begin
    free_any_o = 1'b0;
    idx_o      = '0;
    oh_o       = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (!busy_i[i] && !free_any_o) begin
        free_any_o = 1'b1;
        idx_o      = IDX_W'(i);
        oh_o[i]    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_select.sv
`timescale 1ns/1ps
module rs_select #(
  parameter int N_ENT = 3,
  parameter int AGE_W = 2
) (
  input  logic [N_ENT-1:0]            ready_i,
  input  logic [N_ENT-1:0][AGE_W-1:0] age_i,
  output logic [N_ENT-1:0]            win_o
);
  // ages of busy entries are distinct, so at most one winner
  always_comb begin
    win_o = '0;
    for (int i = 0; i < N_ENT; i++) begin
      win_o[i] = ready_i[i];
      for (int j = 0; j < N_ENT; j++) begin
        if (j != i && ready_i[j] && age_i[j] > age_i[i]) win_o[i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/rs_entry.sv
`timescale 1ns/1ps
module rs_entry
  import rs_pool_pkg::*;
#(
  parameter int AGE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [OP_W-1:0]   op_i,
  input  opnd_t             a_i,
  input  opnd_t             b_i,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  input  logic              grant_i,
  input  logic              free_i,
  input  logic              issue_fire_i,
  input  logic              free_fire_i,
  input  logic [AGE_W-1:0]  free_age_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic [OP_W-1:0]   op_o,
  output opnd_t             a_o,
  output opnd_t             b_o,
  output logic [AGE_W-1:0]  age_o
);
  logic              busy_q, exec_q;
  logic [OP_W-1:0]   op_q;
  opnd_t             a_q, b_q;
  logic [AGE_W-1:0]  age_q, age_nx;

  // rank: count of younger busy entries, kept dense on release
  always_comb begin
    age_nx = age_q;
    if (issue_fire_i) age_nx = age_nx + AGE_W'(1);
    if (free_fire_i && free_age_i < age_q) age_nx = age_nx - AGE_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      exec_q <= 1'b0;
      op_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      age_q  <= '0;
    end else if (alloc_i) begin
      busy_q <= 1'b1;
      exec_q <= 1'b0;
      op_q   <= op_i;
      a_q    <= snoop(a_i, bc_valid_i, bc_tag_i, bc_data_i);
      b_q    <= snoop(b_i, bc_valid_i, bc_tag_i, bc_data_i);
      age_q  <= '0;
    end else if (busy_q) begin
      if (free_i) begin
        busy_q <= 1'b0;
        exec_q <= 1'b0;
      end else begin
        if (grant_i) exec_q <= 1'b1;
        a_q   <= snoop(a_q, bc_valid_i, bc_tag_i, bc_data_i);
        b_q   <= snoop(b_q, bc_valid_i, bc_tag_i, bc_data_i);
        age_q <= age_nx;
      end
    end
  end

  assign busy_o  = busy_q;
  assign ready_o = busy_q && !exec_q && a_q.tag == '0 && b_q.tag == '0;
  assign op_o    = op_q;
  assign a_o     = a_q;
  assign b_o     = b_q;
  assign age_o   = age_q;
endmodule

// File: rtl/rs_pool.sv
`timescale 1ns/1ps
module rs_pool
  import rs_pool_pkg::*;
#(
  parameter int N_ENT    = 3,
  parameter int TAG_BASE = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_valid_i,
  input  logic [OP_W-1:0]   iss_op_i,
  input  logic [TAG_W-1:0]  iss_a_tag_i,
  input  logic [DATA_W-1:0] iss_a_val_i,
  input  logic [TAG_W-1:0]  iss_b_tag_i,
  input  logic [DATA_W-1:0] iss_b_val_i,
  output logic              iss_ready_o,
  output logic [TAG_W-1:0]  iss_slot_o,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  output logic              disp_valid_o,
  input  logic              disp_ready_i,
  output logic [OP_W-1:0]   disp_op_o,
  output logic [DATA_W-1:0] disp_a_o,
  output logic [DATA_W-1:0] disp_b_o,
  output logic [TAG_W-1:0]  disp_tag_o,
  input  logic              free_valid_i,
  input  logic [TAG_W-1:0]  free_tag_i
);
  localparam int IDX_W = $clog2(N_ENT);
  localparam int AGE_W = IDX_W;

  logic [N_ENT-1:0]             busy_vec, ready_vec, win_vec, grant_vec, alloc_oh;
  logic [N_ENT-1:0][TAG_W-1:0]  qa_vec, qb_vec;
  logic [N_ENT-1:0][AGE_W-1:0]  age_arr;
  logic [OP_W-1:0]              op_arr [N_ENT];
  opnd_t                        a_arr  [N_ENT];
  opnd_t                        b_arr  [N_ENT];
  logic                         free_any, issue_fire, free_fire;
  logic [IDX_W-1:0]             alloc_idx, free_idx;
  logic [TAG_W-1:0]             free_off;
  opnd_t                        iss_a, iss_b;

  rs_alloc #(.N_ENT(N_ENT)) u_alloc (
    .busy_i     (busy_vec),
    .free_any_o (free_any),
    .idx_o      (alloc_idx),
    .oh_o       (alloc_oh)
  );

  assign issue_fire = iss_valid_i && free_any;
  assign free_off   = free_tag_i - TAG_W'(TAG_BASE);
  assign free_idx   = IDX_W'(free_off);
  assign free_fire  = free_valid_i && free_off < TAG_W'(N_ENT) && busy_vec[free_idx];
  assign iss_a      = '{tag: iss_a_tag_i, val: iss_a_val_i};
  assign iss_b      = '{tag: iss_b_tag_i, val: iss_b_val_i};

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    rs_entry #(.AGE_W(AGE_W)) u_ent (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .alloc_i      (issue_fire && alloc_oh[g]),
      .op_i         (iss_op_i),
      .a_i          (iss_a),
      .b_i          (iss_b),
      .bc_valid_i   (bc_valid_i),
      .bc_tag_i     (bc_tag_i),
      .bc_data_i    (bc_data_i),
      .grant_i      (grant_vec[g]),
      .free_i       (free_fire && free_idx == IDX_W'(g)),
      .issue_fire_i (issue_fire),
      .free_fire_i  (free_fire),
      .free_age_i   (age_arr[free_idx]),
      .busy_o       (busy_vec[g]),
      .ready_o      (ready_vec[g]),
      .op_o         (op_arr[g]),
      .a_o          (a_arr[g]),
      .b_o          (b_arr[g]),
      .age_o        (age_arr[g])
    );
    assign qa_vec[g] = a_arr[g].tag;
    assign qb_vec[g] = b_arr[g].tag;
  end

  rs_select #(.N_ENT(N_ENT), .AGE_W(AGE_W)) u_sel (
    .ready_i (ready_vec),
    .age_i   (age_arr),
    .win_o   (win_vec)
  );

  assign grant_vec = win_vec & {N_ENT{disp_ready_i}};

  always_comb begin
    disp_op_o  = '0;
    disp_a_o   = '0;
    disp_b_o   = '0;
    disp_tag_o = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (win_vec[i]) begin
        disp_op_o  = disp_op_o  | op_arr[i];
        disp_a_o   = disp_a_o   | a_arr[i].val;
        disp_b_o   = disp_b_o   | b_arr[i].val;
        disp_tag_o = disp_tag_o | TAG_W'(TAG_BASE + i);
      end
    end
  end

  assign disp_valid_o = |win_vec;
  assign iss_ready_o  = free_any;
  assign iss_slot_o   = TAG_W'(TAG_BASE) + TAG_W'(alloc_idx);
endmodule

// File: rtl/rs_pool_chk.sv
`timescale 1ns/1ps
module rs_pool_chk
  import rs_pool_pkg::*;
#(
  parameter int N_ENT    = 3,
  parameter int TAG_BASE = 1
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        iss_valid_i,
  input logic                        iss_ready_o,
  input logic [TAG_W-1:0]            iss_slot_o,
  input logic                        bc_valid_i,
  input logic [TAG_W-1:0]            bc_tag_i,
  input logic                        disp_valid_o,
  input logic                        disp_ready_i,
  input logic [TAG_W-1:0]            disp_tag_o,
  input logic                        free_valid_i,
  input logic [TAG_W-1:0]            free_tag_i,
  input logic [N_ENT-1:0]            busy_vec,
  input logic [N_ENT-1:0]            grant_vec,
  input logic [N_ENT-1:0][TAG_W-1:0] qa_vec,
  input logic [N_ENT-1:0][TAG_W-1:0] qb_vec
);
  localparam int IDX_W = $clog2(N_ENT);

  logic [TAG_W-1:0] free_off, disp_off;
  logic [IDX_W-1:0] slot_idx, free_idx, disp_idx;
  logic             free_hit;

  assign slot_idx = IDX_W'(iss_slot_o - TAG_W'(TAG_BASE));
  assign disp_off = disp_tag_o - TAG_W'(TAG_BASE);
  assign disp_idx = IDX_W'(disp_off);
  assign free_off = free_tag_i - TAG_W'(TAG_BASE);
  assign free_idx = IDX_W'(free_off);
  assign free_hit = free_valid_i && free_off < TAG_W'(N_ENT) && busy_vec[free_idx];

  // R2
  alloc_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_i && iss_ready_o) |=> busy_vec[$past(slot_idx)]);

  // R2
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iss_ready_o |=> $countones(busy_vec) <= $countones($past(busy_vec)));

  // R6
  disp_ready_ops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> (disp_off < TAG_W'(N_ENT) && busy_vec[disp_idx]
                      && qa_vec[disp_idx] == '0 && qb_vec[disp_idx] == '0));

  // R7
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_vec));

  // R8
  no_regrant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_o && disp_ready_i) |=> !(disp_valid_o && disp_tag_o == $past(disp_tag_o)));

  // R9
  free_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_hit |=> !busy_vec[$past(free_idx)]);

  for (genvar g = 0; g < N_ENT; g++) begin : g_wk
    // R4
    wake_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bc_valid_i && bc_tag_i != '0) |=>
        !(busy_vec[g] && (qa_vec[g] == $past(bc_tag_i) || qb_vec[g] == $past(bc_tag_i))));
  end
endmodule

bind rs_pool rs_pool_chk #(.N_ENT(N_ENT), .TAG_BASE(TAG_BASE)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .iss_valid_i  (iss_valid_i),
  .iss_ready_o  (iss_ready_o),
  .iss_slot_o   (iss_slot_o),
  .bc_valid_i   (bc_valid_i),
  .bc_tag_i     (bc_tag_i),
  .disp_valid_o (disp_valid_o),
  .disp_ready_i (disp_ready_i),
  .disp_tag_o   (disp_tag_o),
  .free_valid_i (free_valid_i),
  .free_tag_i   (free_tag_i),
  .busy_vec     (busy_vec),
  .grant_vec    (grant_vec),
  .qa_vec       (qa_vec),
  .qb_vec       (qb_vec)
);

// File: tb/rs_pool_test.sv
`timescale 1ns/1ps
module rs_pool_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        iss_valid_i = 1'b0;
  logic [3:0]  iss_op_i = '0;
  logic [3:0]  iss_a_tag_i = '0;
  logic [63:0] iss_a_val_i = '0;
  logic [3:0]  iss_b_tag_i = '0;
  logic [63:0] iss_b_val_i = '0;
  logic        iss_ready_o;
  logic [3:0]  iss_slot_o;
  logic        bc_valid_i = 1'b0;
  logic [3:0]  bc_tag_i = '0;
  logic [63:0] bc_data_i = '0;
  logic        disp_valid_o;
  logic        disp_ready_i = 1'b0;
  logic [3:0]  disp_op_o;
  logic [63:0] disp_a_o, disp_b_o;
  logic [3:0]  disp_tag_o;
  logic        free_valid_i = 1'b0;
  logic [3:0]  free_tag_i = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rs_pool uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .iss_valid_i(iss_valid_i), .iss_op_i(iss_op_i),
    .iss_a_tag_i(iss_a_tag_i), .iss_a_val_i(iss_a_val_i),
    .iss_b_tag_i(iss_b_tag_i), .iss_b_val_i(iss_b_val_i),
    .iss_ready_o(iss_ready_o), .iss_slot_o(iss_slot_o),
    .bc_valid_i(bc_valid_i), .bc_tag_i(bc_tag_i), .bc_data_i(bc_data_i),
    .disp_valid_o(disp_valid_o), .disp_ready_i(disp_ready_i),
    .disp_op_o(disp_op_o), .disp_a_o(disp_a_o), .disp_b_o(disp_b_o),
    .disp_tag_o(disp_tag_o),
    .free_valid_i(free_valid_i), .free_tag_i(free_tag_i)
  );

  typedef struct packed {
    logic iv; logic [3:0] op; logic [3:0] qa; logic [15:0] va; logic [3:0] qb; logic [15:0] vb;
    logic bv; logic [3:0] bt; logic [15:0] bd;
    logic dr; logic fv; logic [3:0] ft;
    logic e_rdy; logic [3:0] e_slot;
    logic e_dv; logic [3:0] e_tag; logic [3:0] e_op; logic [15:0] e_a; logic [15:0] e_b;
  } step_t;

  localparam int NSTEP = 18;
  // inputs applied this cycle; expectations are the outputs before this cycle's edge
  localparam step_t STEPS [NSTEP] = '{
    // R1 idle pool
    '{1'b0,4'd0,4'd0,16'd0,4'd0,16'd0, 1'b0,4'd0,16'd0, 1'b0,1'b0,4'd0, 1'b1,4'd1, 1'b0,4'd0,4'd0,16'd0,16'd0},
    // R2 R3 ready issue into slot 1
    '{1'b1,4'd1,4'd0,16'd10,4'd0,16'd20, 1'b0,4'd0,16'd0, 1'b0,1'b0,4'd0, 1'b1,4'd1, 1'b0,4'd0,4'd0,16'd0,16'd0},
    // R3 R6 R10 waiting issue, slot 1 offered
    '{1'b1,4'd2,4'd5,16'd0,4'd0,16'd7, 1'b0,4'd0,16'd0, 1'b0,1'b0,4'd0, 1'b1,4'd2, 1'b1,4'd1,4'd1,16'd10,16'd20},
    // R8 stalled offer holds
    '{1'b1,4'd3,4'd6,16'd0,4'd6,16'd0, 1'b0,4'd0,16'd0, 1'b0,1'b0,4'd0, 1'b1,4'd3, 1'b1,4'd1,4'd1,16'd10,16'd20},
    // R2 full pool drops request
    '{1'b1,4'd15,4'd0,16'd99,4'd0,16'd99, 1'b0,4'd0,16'd0, 1'b0,1'b0,4'd0, 1'b0,4'd0, 1'b1,4'd1,4'd1,16'd10,16'd20},
    // R4 wake slot 3 on both operands, accept slot 1
    '{1'b0,4'd0,4'd0,16'd0,4'd0,16'd0, 1'b1,4'd6,16'd30, 1'b1,1'b0,4'd0, 1'b0,4'd0, 1'b1,4'd1,4'd1,16'd10,16'd20},
    // R4 R8 slot 3 offered, wake slot 2
    '{1'b0,4'd0,4'd0,16'd0,4'd0,16'd0, 1'b1,4'd5,16'd40, 1'b0,1'b0,4'd0, 1'b0,4'd0, 1'b1,4'd3,4'd3,16'd30,16'd30},
    // R7 older slot 2 wins, accept; release slot 1
    '{1'b0,4'd0,4'd0,16'd0,4'd0,16'd0, 1'b0,4'd0,16'd0, 1'b1,1'b1,4'd1, 1'b0,4'd0, 1'b1,4'd2,4'd2,16'd40,16'd7},
    // R5 issue meets matching broadcast; R9 release slot 2
    '{1'b1,4'd4,4'd7,16'd0,4'd0,16'd3, 1'b1,4'd7,16'd50, 1'b1,1'b1,4'd2, 1'b1,4'd1, 1'b1,4'd3,4'd3,16'd30,16'd30},
    // R5 captured value; R11 tag 0 broadcast
    '{1'b0,4'd0,4'd0,16'd0,4'd0,16'd0, 1'b1,4'd0,16'd77, 1'b0,1'b1,4'd3, 1'b1,4'd2, 1'b1,4'd1,4'd4,16'd50,16'd3},
    // R11 unmatched tag broadcast
    '{1'b1,4'd5,4'd0,16'd1,4'd0,16'd2, 1'b1,4'd9,16'd88, 1'b0,1'b0,4'd0, 1'b1,4'd2, 1'b1,4'd1,4'd4,16'd50,16'd3},
    // R10 accept slot 1
    '{1'b1,4'd6,4'd0,16'd4,4'd0,16'd5, 1'b0,4'd0,16'd0, 1'b1,1'b0,4'd0, 1'b1,4'd3, 1'b1,4'd1,4'd4,16'd50,16'd3},
    // R7 release slot 1
    '{1'b0,4'd0,4'd0,16'd0,4'd0,16'd0, 1'b0,4'd0,16'd0, 1'b0,1'b1,4'd1, 1'b0,4'd0, 1'b1,4'd2,4'd5,16'd1,16'd2},
    // R9 reuse slot 1
    '{1'b1,4'd7,4'd0,16'd8,4'd0,16'd9, 1'b0,4'd0,16'd0, 1'b0,1'b0,4'd0, 1'b1,4'd1, 1'b1,4'd2,4'd5,16'd1,16'd2},
    // R7 slot 2 older than new slot 1
    '{1'b0,4'd0,4'd0,16'd0,4'd0,16'd0, 1'b0,4'd0,16'd0, 1'b1,1'b0,4'd0, 1'b0,4'd0, 1'b1,4'd2,4'd5,16'd1,16'd2},
    // R7 slot 3 before slot 1
    '{1'b0,4'd0,4'd0,16'd0,4'd0,16'd0, 1'b0,4'd0,16'd0, 1'b1,1'b0,4'd0, 1'b0,4'd0, 1'b1,4'd3,4'd6,16'd4,16'd5},
    // R7 youngest last
    '{1'b0,4'd0,4'd0,16'd0,4'd0,16'd0, 1'b0,4'd0,16'd0, 1'b1,1'b0,4'd0, 1'b0,4'd0, 1'b1,4'd1,4'd7,16'd8,16'd9},
    // R8 all dispatched, nothing offered
    '{1'b0,4'd0,4'd0,16'd0,4'd0,16'd0, 1'b0,4'd0,16'd0, 1'b0,1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0,4'd0,16'd0,16'd0}
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s step/time %0t actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic idle();
    iss_valid_i = 1'b0; iss_op_i = '0; iss_a_tag_i = '0; iss_a_val_i = '0;
    iss_b_tag_i = '0; iss_b_val_i = '0;
    bc_valid_i = 1'b0; bc_tag_i = '0; bc_data_i = '0;
    disp_ready_i = 1'b0; free_valid_i = 1'b0; free_tag_i = '0;
  endtask

  task automatic issue(logic [3:0] op, logic [3:0] qa, logic [63:0] va,
                       logic [3:0] qb, logic [63:0] vb);
    iss_valid_i = 1'b1; iss_op_i = op;
    iss_a_tag_i = qa; iss_a_val_i = va; iss_b_tag_i = qb; iss_b_val_i = vb;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", 64'(iss_ready_o), 64'd1);
    chk("R1", 64'(iss_slot_o), 64'd1);
    chk("R1", 64'(disp_valid_o), 64'd0);
    rst_ni = 1'b1;

    for (int s = 0; s < NSTEP; s++) begin
      step_t r;
      r = STEPS[s];
      @(negedge clk);
      iss_valid_i = r.iv; iss_op_i = r.op;
      iss_a_tag_i = r.qa; iss_a_val_i = 64'(r.va);
      iss_b_tag_i = r.qb; iss_b_val_i = 64'(r.vb);
      bc_valid_i = r.bv; bc_tag_i = r.bt; bc_data_i = 64'(r.bd);
      disp_ready_i = r.dr; free_valid_i = r.fv; free_tag_i = r.ft;
      #2;
      chk("R2 issue ready", 64'(iss_ready_o), 64'(r.e_rdy));
      if (r.e_rdy) chk("R2 slot", 64'(iss_slot_o), 64'(r.e_slot));
      chk("R6 disp valid", 64'(disp_valid_o), 64'(r.e_dv));
      if (r.e_dv) begin
        chk("R7 disp tag", 64'(disp_tag_o), 64'(r.e_tag));
        chk("R10 disp op", 64'(disp_op_o), 64'(r.e_op));
        chk("R10 disp a", disp_a_o, 64'(r.e_a));
        chk("R10 disp b", disp_b_o, 64'(r.e_b));
      end
    end

    // R1 reset with a busy pool
    @(negedge clk); idle(); rst_ni = 1'b0;
    #2;
    chk("R1", 64'(iss_ready_o), 64'd1);
    chk("R1", 64'(iss_slot_o), 64'd1);
    chk("R1", 64'(disp_valid_o), 64'd0);
    @(negedge clk); rst_ni = 1'b1;

    // R9 releases of an out-of-range tag and of an empty entry are ignored
    @(negedge clk); issue(4'd1, 4'd0, 64'h11, 4'd0, 64'h22);
    @(negedge clk); idle(); free_valid_i = 1'b1; free_tag_i = 4'd12;
    @(negedge clk); free_tag_i = 4'd2;
    @(negedge clk); idle();
    #2;
    chk("R9 ignored free", 64'(disp_valid_o), 64'd1);
    chk("R9 ignored free", 64'(disp_tag_o), 64'd1);
    chk("R9 ignored free", 64'(iss_slot_o), 64'd2);
    @(negedge clk); free_valid_i = 1'b1; free_tag_i = 4'd1;
    @(negedge clk); idle();
    #2;
    chk("R9 released", 64'(disp_valid_o), 64'd0);
    chk("R9 released", 64'(iss_slot_o), 64'd1);

    // R4 woken entry appears the cycle after the broadcast
    @(negedge clk); issue(4'd2, 4'd8, 64'd0, 4'd0, 64'd3);
    @(negedge clk); idle(); bc_valid_i = 1'b1; bc_tag_i = 4'd8; bc_data_i = 64'h0123_4567_89ab_cdef;
    #2;
    chk("R4 not in broadcast cycle", 64'(disp_valid_o), 64'd0);
    @(negedge clk); idle();
    #2;
    chk("R4 next cycle", 64'(disp_valid_o), 64'd1);
    chk("R4 captured data", disp_a_o, 64'h0123_4567_89ab_cdef);
    chk("R4 other operand", disp_b_o, 64'd3);

    done = 1'b1;
    finish_run();
  end
endmodule